// File: doc/BRIEF.md
# Reference Clock Loss Monitor with Automatic Revert

This block supervises two reference clocks with a free-running local clock. Each reference passes through a two-flop synchronizer. A per-input health monitor then counts local cycles between synchronized rising edges. If an enabled reference goes `TIMEOUT` local cycles without a rising edge, it is declared lost. Its sticky status bit sets and the interrupt line rises. A lost reference only counts as healthy again after `RECOVER_CNT` complete periods in a row, each of them shorter than the timeout.

A selection state machine chooses which reference drives the downstream loop. It prefers the input named by `pref_sel` and falls back to the other input when the preferred one is unusable. It asserts holdover when neither input is usable. With `revert_en` high, a recovered input clears its own status bit, and the selector returns to the preferred input once that input is usable again. With `revert_en` low, status bits stay set until the host writes `status_clr`, and the selector stays on the backup for as long as the backup remains usable.

Per-input monitor states: `MON_OFF` (input disabled), `MON_OK` (edges arriving in time), `MON_LOST` (timeout expired, waiting for an edge), `MON_RECOV` (counting good periods).
- Monitor transitions:
  - OFF→OK when enabled.
  - OK→LOST on timeout; this is the failure event.
  - LOST→RECOV on the first edge.
  - RECOV→OK after the required good periods; this is the recovery event.
  - RECOV→LOST on another timeout.
  - Any state→OFF when disabled.
- Selector states: `SEL_PREF`, `SEL_BACKUP`, `SEL_HOLD`.
- Selector transitions:
  - PREF→BACKUP when the preferred input is unusable and the other is usable.
  - PREF→HOLD when neither input is usable.
  - BACKUP→PREF when revert is on and the preferred input is usable, or when the backup is lost but the preferred input is usable.
  - BACKUP→HOLD when both inputs are unusable.
  - HOLD→PREF when the preferred input is usable.
  - HOLD→BACKUP when only the other input is usable.
  - Reset enters HOLD.

Top module: `refclk_guard`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `holdover`=1, `irq`=0, `status`=00 and `sel`=`pref_sel`.
- R2: An enabled input is declared lost when `TIMEOUT` consecutive local cycles pass without a synchronized rising edge on it. Rising edges are seen through a two-flop synchronizer. On that cycle the input's status bit sets and `irq` rises.
- R3: An input whose enable bit is 0 never sets its status bit and is never selected.
- R4: The preferred input is selected whenever it is usable (enabled and healthy) and the selector is not held on the backup. When the selected input becomes unusable and the other input is usable, `sel` moves to the other input.
- R5: When neither input is usable, `holdover` is 1 from the next cycle, and `sel` then shows `pref_sel`.
- R6: With `revert_en`=1, a lost input becomes healthy again after its first edge plus `RECOVER_CNT` further edges, each arriving within `TIMEOUT` cycles of the one before. On recovery its status bit clears and selection returns to the preferred input.
- R7: With `revert_en`=0, status bits clear only through `status_clr`, and the selector stays on the backup while the backup is usable, even after the preferred input recovers.
- R8: A 1 in `status_clr[i]` for one cycle clears `status[i]` on the next edge. A failure event in the same cycle takes priority and sets the bit.
- R9: `irq` is the OR of the status bits. `status[0]` belongs to `ref_clk[0]` and `status[1]` to `ref_clk[1]`. `sel`=0 means `ref_clk[0]` is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local stable monitoring clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 2 | The two reference clocks (asynchronous) |
| ref_en | input | 2 | Per-input monitor and selection enable |
| pref_sel | input | 1 | Index of the preferred reference |
| revert_en | input | 1 | Automatic clear and return on recovery |
| status_clr | input | 2 | Host clear of the sticky status bits |
| sel | output | 1 | Index of the reference feeding the loop |
| holdover | output | 1 | No usable reference |
| irq | output | 1 | Interrupt, high while any status bit is set |
| status | output | 2 | Sticky per-input loss flags |

## Verification
The selection assertion assumes that `pref_sel` changes only rarely, and it checks only on cycles where `pref_sel` held its value across the edge. For that reason the stimulus changes `pref_sel` just once, while both references are running. The assertions also assume that each reference's half period is several local cycles long, so that the synchronizer sees each edge. The generated references use half periods of 3 and 4 local cycles, well inside the 16-cycle timeout. Control inputs and reference toggles are driven on the falling edge of the local clock, so each rising edge sees settled values.

// File: rtl/refclk_guard_pkg.sv
package refclk_guard_pkg;
    typedef enum logic [1:0] {
        MON_OFF   = 2'd0,
        MON_OK    = 2'd1,
        MON_LOST  = 2'd2,
        MON_RECOV = 2'd3
    } mon_state_t;

    typedef enum logic [1:0] {
        SEL_PREF   = 2'd0,
        SEL_BACKUP = 2'd1,
        SEL_HOLD   = 2'd2
    } sel_state_t;
endpackage

// File: rtl/refclk_edge_sync.sv
module refclk_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [2:0] shreg;

    always_ff @(posedge clk) begin
        if (!rst_n) shreg <= '0;
        else        shreg <= {shreg[1:0], async_in};
    end

    assign rise = shreg[1] & ~shreg[2];
endmodule

// File: rtl/refclk_health_mon.sv
module refclk_health_mon
    import refclk_guard_pkg::*;
#(
    parameter int TIMEOUT     = 16,
    parameter int RECOVER_CNT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic rise,
    output logic healthy,
    output logic fail_evt,
    output logic recov_evt
);
    localparam int CNT_W  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam int GOOD_W = (RECOVER_CNT > 1) ? $clog2(RECOVER_CNT) : 1;
    localparam logic [CNT_W-1:0]  LIMIT     = CNT_W'(TIMEOUT - 1);
    localparam logic [GOOD_W-1:0] GOOD_LAST = GOOD_W'(RECOVER_CNT - 1);

    mon_state_t        st, st_n;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [GOOD_W-1:0] good, good_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= MON_OFF;
            cnt  <= '0;
            good <= '0;
        end else begin
            st   <= st_n;
            cnt  <= cnt_n;
            good <= good_n;
        end
    end

    always_comb begin
        st_n      = st;
        cnt_n     = cnt;
        good_n    = good;
        fail_evt  = 1'b0;
        recov_evt = 1'b0;
        if (!en) begin
            st_n   = MON_OFF;
            cnt_n  = '0;
            good_n = '0;
        end else begin
            unique case (st)
                MON_OFF: begin
                    st_n  = MON_OK;
                    cnt_n = '0;
                end
                MON_OK: begin
                    if (rise) begin
                        cnt_n = '0;
                    end else if (cnt == LIMIT) begin
                        st_n     = MON_LOST;
                        fail_evt = 1'b1;
                        cnt_n    = '0;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                MON_LOST: begin
                    if (rise) begin
                        st_n   = MON_RECOV;
                        cnt_n  = '0;
                        good_n = '0;
                    end
                end
                MON_RECOV: begin
                    if (rise) begin
                        cnt_n = '0;
                        if (good == GOOD_LAST) begin
                            st_n      = MON_OK;
                            recov_evt = 1'b1;
                            good_n    = '0;
                        end else begin
                            good_n = good + GOOD_W'(1);
                        end
                    end else if (cnt == LIMIT) begin
                        st_n   = MON_LOST;
                        cnt_n  = '0;
                        good_n = '0;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                default: st_n = MON_OFF;
            endcase
        end
    end

    assign healthy = (st == MON_OK);

    // R2
    lost_needs_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(healthy) && $past(en)) |-> !$past(rise));

    // R6
    healthy_from_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(healthy) && $past(st != MON_OFF)) |-> $past(rise));
endmodule

// File: rtl/refclk_path_select.sv
module refclk_path_select
    import refclk_guard_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] en,
    input  logic [1:0] healthy,
    input  logic       pref_sel,
    input  logic       revert_en,
    output logic       sel,
    output logic       holdover
);
    sel_state_t st, st_n;
    logic [1:0] usable;
    logic       pref_ok, alt_ok;

    always_comb begin
        usable  = en & healthy;
        pref_ok = usable[pref_sel];
        alt_ok  = usable[~pref_sel];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= SEL_HOLD;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            SEL_PREF: begin
                if (!pref_ok) st_n = alt_ok ? SEL_BACKUP : SEL_HOLD;
            end
            SEL_BACKUP: begin
                if (revert_en && pref_ok) st_n = SEL_PREF;
                else if (!alt_ok)         st_n = pref_ok ? SEL_PREF : SEL_HOLD;
            end
            SEL_HOLD: begin
                if (pref_ok)     st_n = SEL_PREF;
                else if (alt_ok) st_n = SEL_BACKUP;
            end
            default: st_n = SEL_HOLD;
        endcase
    end

    always_comb begin
        sel      = (st == SEL_BACKUP) ? ~pref_sel : pref_sel;
        holdover = (st == SEL_HOLD);
    end

    // R5
    hold_when_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(usable == 2'b00) |-> holdover);

    // R4
    sel_was_usable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!holdover && $stable(pref_sel)) |->
            (($past(usable) & (sel ? 2'b10 : 2'b01)) != 2'b00));
endmodule

// File: rtl/refclk_guard.sv
module refclk_guard
    import refclk_guard_pkg::*;
#(
    parameter int TIMEOUT     = 16,
    parameter int RECOVER_CNT = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ref_clk,
    input  logic [1:0] ref_en,
    input  logic       pref_sel,
    input  logic       revert_en,
    input  logic [1:0] status_clr,
    output logic       sel,
    output logic       holdover,
    output logic       irq,
    output logic [1:0] status
);
    localparam int NREF = 2;

    logic [NREF-1:0] rise, healthy, fail_evt, recov_evt;

    for (genvar g = 0; g < NREF; g++) begin : g_ref
        refclk_edge_sync u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (ref_clk[g]),
            .rise     (rise[g])
        );

        refclk_health_mon #(
            .TIMEOUT     (TIMEOUT),
            .RECOVER_CNT (RECOVER_CNT)
        ) u_mon (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (ref_en[g]),
            .rise      (rise[g]),
            .healthy   (healthy[g]),
            .fail_evt  (fail_evt[g]),
            .recov_evt (recov_evt[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n)
                status[g] <= 1'b0;
            else if (fail_evt[g])
                status[g] <= 1'b1;
            else if (status_clr[g] || (revert_en && recov_evt[g]))
                status[g] <= 1'b0;
        end

        // R3
        status_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[g]) |-> $past(ref_en[g]));

        // R7
        sticky_without_revert_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($fell(status[g]) && !$past(revert_en)) |-> $past(status_clr[g]));
    end

    refclk_path_select u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (ref_en),
        .healthy   (healthy),
        .pref_sel  (pref_sel),
        .revert_en (revert_en),
        .sel       (sel),
        .holdover  (holdover)
    );

    assign irq = |status;
endmodule

// File: tb/refclk_guard_bench.sv
`timescale 1ns/1ps
module refclk_guard_bench;
    localparam int TO = 16;
    localparam int RC = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ref_clk = 2'b00;
    logic [1:0] ref_en = 2'b11;
    logic       pref_sel = 1'b0;
    logic       revert_en = 1'b1;
    logic [1:0] status_clr = 2'b00;
    logic       sel, holdover, irq;
    logic [1:0] status;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit armed = 0;

    always #2.5 clk = ~clk;

    refclk_guard #(.TIMEOUT(TO), .RECOVER_CNT(RC)) u_refclk_guard (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .ref_en(ref_en),
        .pref_sel(pref_sel), .revert_en(revert_en), .status_clr(status_clr),
        .sel(sel), .holdover(holdover), .irq(irq), .status(status)
    );

    // reference generators, toggled on the falling edge
    logic [1:0] run = 2'b11;
    int ph[2] = '{0, 0};
    always @(negedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (run[i]) begin
                ph[i]++;
                if (ph[i] >= (i == 0 ? 3 : 4)) begin
                    ph[i] = 0;
                    ref_clk[i] = ~ref_clk[i];
                end
            end
        end
    end

    // behavioural reference model
    int s1[2], s2[2], s3[2], mst[2], mcnt[2], mgood[2], mstat[2];
    int msel;
    always @(posedge clk) begin
        int u[2];
        int fe[2];
        int re[2];
        int p;
        int o;
        armed = 1;
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                s1[i] = 0; s2[i] = 0; s3[i] = 0;
                mst[i] = 0; mcnt[i] = 0; mgood[i] = 0; mstat[i] = 0;
            end
            msel = 2;
        end else begin
            for (int i = 0; i < 2; i++) u[i] = (ref_en[i] && mst[i] == 1) ? 1 : 0;
            for (int i = 0; i < 2; i++) begin
                int r;
                r = (s2[i] == 1 && s3[i] == 0) ? 1 : 0;
                fe[i] = 0; re[i] = 0;
                if (!ref_en[i]) begin
                    mst[i] = 0; mcnt[i] = 0; mgood[i] = 0;
                end else if (mst[i] == 0) begin
                    mst[i] = 1; mcnt[i] = 0;
                end else if (mst[i] == 1) begin
                    if (r == 1) mcnt[i] = 0;
                    else if (mcnt[i] == TO - 1) begin mst[i] = 2; fe[i] = 1; mcnt[i] = 0; end
                    else mcnt[i]++;
                end else if (mst[i] == 2) begin
                    if (r == 1) begin mst[i] = 3; mcnt[i] = 0; mgood[i] = 0; end
                end else begin
                    if (r == 1) begin
                        mcnt[i] = 0;
                        if (mgood[i] == RC - 1) begin mst[i] = 1; re[i] = 1; mgood[i] = 0; end
                        else mgood[i]++;
                    end else if (mcnt[i] == TO - 1) begin
                        mst[i] = 2; mcnt[i] = 0; mgood[i] = 0;
                    end else mcnt[i]++;
                end
                s3[i] = s2[i]; s2[i] = s1[i]; s1[i] = ref_clk[i];
            end
            p = pref_sel; o = 1 - p;
            if (msel == 0) begin
                if (u[p] == 0) msel = (u[o] == 1) ? 1 : 2;
            end else if (msel == 1) begin
                if (revert_en && u[p] == 1) msel = 0;
                else if (u[o] == 0) msel = (u[p] == 1) ? 0 : 2;
            end else begin
                if (u[p] == 1) msel = 0;
                else if (u[o] == 1) msel = 1;
            end
            for (int i = 0; i < 2; i++) begin
                if (fe[i] == 1) mstat[i] = 1;
                else if (status_clr[i] || (revert_en && re[i] == 1)) mstat[i] = 0;
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (armed && !done) begin
            int exp_sel;
            exp_sel = (msel == 1) ? 1 - pref_sel : pref_sel;
            check("R4 sel vs model", sel, exp_sel);
            check("R5 holdover vs model", holdover, (msel == 2) ? 1 : 0);
            check("R2 status vs model", status, mstat[1] * 2 + mstat[0]);
            check("R9 irq vs model", irq, (mstat[0] | mstat[1]));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(5);
        check("R1 reset holdover", holdover, 1);
        check("R1 reset irq", irq, 0);
        check("R1 reset status", status, 0);
        check("R1 reset sel", sel, 0);
        rst_n = 1'b1;
        wait_cyc(1);
        check("R1 first cycle holdover", holdover, 1);
        wait_cyc(40);
        check("R4 preferred selected", sel, 0);
        check("R5 no holdover when healthy", holdover, 0);

        run[0] = 1'b0;          // preferred lost
        wait_cyc(30);
        check("R2 status bit 0 set", status, 2'b01);
        check("R9 irq on loss", irq, 1);
        check("R4 switched to backup", sel, 1);

        run[0] = 1'b1;          // recover with revert on
        wait_cyc(50);
        check("R6 status cleared on recovery", status, 2'b00);
        check("R6 irq cleared", irq, 0);
        check("R6 back to preferred", sel, 0);

        revert_en = 1'b0;
        run[0] = 1'b0;
        wait_cyc(30);
        check("R7 loss without revert", status, 2'b01);
        run[0] = 1'b1;
        wait_cyc(60);
        check("R7 status sticky", status, 2'b01);
        check("R7 stays on backup", sel, 1);
        status_clr = 2'b01;
        wait_cyc(1);
        status_clr = 2'b00;
        check("R8 host clear", status, 2'b00);
        check("R7 still on backup after clear", sel, 1);

        run[1] = 1'b0;          // backup lost
        wait_cyc(30);
        check("R4 backup lost, to preferred", sel, 0);
        check("R9 status bit 1", status, 2'b10);
        run[0] = 1'b0;          // both lost
        wait_cyc(30);
        check("R5 holdover both lost", holdover, 1);
        check("R5 sel shows preferred", sel, 0);
        check("R2 both status bits", status, 2'b11);

        status_clr = 2'b11;
        wait_cyc(1);
        status_clr = 2'b00;
        ref_en = 2'b10;         // input 0 disabled and dead
        run[1] = 1'b1;
        wait_cyc(70);
        check("R3 disabled input no status", status, 2'b00);
        check("R3 disabled input not selected", sel, 1);
        check("R3 backup out of holdover", holdover, 0);

        revert_en = 1'b1;
        run[0] = 1'b1;
        ref_en = 2'b11;
        pref_sel = 1'b1;
        wait_cyc(60);
        check("R4 new preference honoured", sel, 1);
        run[1] = 1'b0;
        wait_cyc(30);
        check("R4 preferred 1 lost", sel, 0);
        check("R9 status bit 1 maps input 1", status, 2'b10);
        wait_cyc(5);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule